// File: doc/BRIEF.md
# Keypad Access-Code Lock with Retry Limit

This block checks an access code entered on a keypad that has one "session" contact and ten digit contacts. The user holds the session contact for the whole entry. Inside that window the user presses the four code digits one at a time, releasing each before the next. The session contact is then released with every contact open. A correct entry produces a one-cycle `go` pulse. Every contact input is one bit and is already synchronous to `clk`.

A wrong entry does not lock the keypad at once. A two-bit failure counter sits beside a single code-tracking sequence, so the user may retry. When the number of failed attempts reaches the retry limit, the lock enters a sticky alarm state. Only the synchronous `restart` input clears that state. Both outputs are registered decodes of the sequencer state, so they appear one clock after the state that produces them.

Top module: `keypad_lock`

## Requirements
- R1: `restart` is synchronous and overrides every other input. On the edge where it is sampled high, the sequencer returns to idle, the failure count clears, and `go` and `alarm` are low after that edge. This holds even when the same edge sees a wrong or completing pattern.
- R2: The accepted code is the digit sequence 1, 7, 2, 4 (parameter `CODE`, first digit in the most significant nibble). Bit n of `digit_keys` is digit n. A press counts only when `init_key` is high and `digit_keys` is exactly the one-hot value of the expected digit.
- R3: Between presses only `init_key` may be high. Holding either the current press pattern or the session-only pattern for any number of cycles is allowed.
- R4: After the last digit is released, an edge that samples every input low completes the entry. `go` rises at the next rising edge and stays high for exactly one clock period.
- R5: During an attempt, any sampled pattern other than the held pattern or the one permitted next pattern is a wrong attempt and adds one to the failure count.
- R6: After a wrong attempt below the limit, every input is ignored until `init_key` is sampled low. A new attempt starts on the next `init_key` assertion.
- R7: The wrong attempt that brings the failure count to `MAX_FAILS` (default 3) enters the alarm state. `alarm` rises at the rising edge after the one that sampled that pattern. It then stays high, and code entries are ignored until `restart`.
- R8: A completed entry clears the failure count. After a success, a full `MAX_FAILS` further wrong attempts are needed to raise `alarm`.
- R9: `go` and `alarm` are never high together, and `go` is never high in two consecutive cycles.
- R10: While idle, digit contacts that are pressed without `init_key` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| restart | input | 1 | Synchronous administrator restart, active high |
| init_key | input | 1 | Session contact, held through an entry |
| digit_keys | input | 10 | Digit contacts, bit n is digit n |
| go | output | 1 | One-cycle access grant pulse |
| alarm | output | 1 | Sticky lockout indication |

## Verification
Two events can fall on the same edge. `restart` may arrive together with the wrong pattern that would reach the retry limit. It may also arrive together with the all-low pattern that would complete a correct entry. The bench drives both coincidences. It judges the first by confirming that no alarm follows and that `MAX_FAILS` fresh wrong attempts are still needed to raise it. It judges the second by confirming that no `go` pulse follows. A sweep also places each of three kinds of wrong pattern at every position of an entry, with the expected alarm computed from a running failure count.

// File: rtl/keypad_lock_pkg.sv
package keypad_lock_pkg;

    localparam int KEY_COUNT = 10;
    localparam int KEY_SEL_W = $clog2(KEY_COUNT);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_PRESS,
        ST_DONE,
        ST_SUCCESS,
        ST_REJECT,
        ST_ALARM
    } lock_state_e;

endpackage

// File: rtl/kl_pattern_decode.sv
module kl_pattern_decode
    import keypad_lock_pkg::*;
(
    input  logic                 init_key,
    input  logic [KEY_COUNT-1:0] digit_keys,
    input  logic [KEY_SEL_W-1:0] want,
    output logic                 all_low,
    output logic                 init_only,
    output logic                 want_hit
);

    logic [KEY_COUNT-1:0] want_vec;

    for (genvar g = 0; g < KEY_COUNT; g++) begin : g_want
        assign want_vec[g] = (want == KEY_SEL_W'(g));
    end

    always_comb begin
        all_low   = !init_key && (digit_keys == '0);
        init_only = init_key && (digit_keys == '0);
        want_hit  = init_key && (digit_keys == want_vec);
    end

endmodule

// File: rtl/kl_fail_counter.sv
module kl_fail_counter #(
    parameter int MAX_FAILS = 3,
    localparam int FAIL_W   = $clog2(MAX_FAILS + 1)
) (
    input  logic              clk,
    input  logic              restart,
    input  logic              bump,
    input  logic              clear,
    output logic [FAIL_W-1:0] count,
    output logic              last_chance
);

    typedef struct packed {
        logic [FAIL_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d.count = '0;
        end else if (bump) begin
            cnt_d.count = cnt_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count       = cnt_q.count;
    assign last_chance = (cnt_q.count == FAIL_W'(MAX_FAILS - 1));

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (restart)
        count <= FAIL_W'(MAX_FAILS));

    a_r5_bump_adds_one: assert property (@(posedge clk) disable iff (restart)
        (bump && !clear) |=> (count == FAIL_W'($past(count) + 1'b1)));

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (restart)
        clear |=> (count == '0));

endmodule

// File: rtl/kl_sequencer.sv
module kl_sequencer
    import keypad_lock_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter logic [NUM_DIGITS*KEY_SEL_W-1:0] CODE = 16'h1724,
    localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                 clk,
    input  logic                 restart,
    input  logic                 init_key,
    input  logic                 all_low,
    input  logic                 init_only,
    input  logic                 want_hit,
    input  logic                 last_chance,
    output logic [KEY_SEL_W-1:0] want,
    output logic                 bump,
    output logic                 clear,
    output logic                 go,
    output logic                 alarm
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DIGITS - 1);

    typedef struct packed {
        lock_state_e      state;
        logic [IDX_W-1:0] idx;
        logic             go;
        logic             alarm;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [KEY_SEL_W-1:0] code_digits [NUM_DIGITS];
    logic                 wrong;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        assign code_digits[g] = CODE[(NUM_DIGITS-1-g)*KEY_SEL_W +: KEY_SEL_W];
    end

    assign want = code_digits[seq_q.idx];

    always_comb begin
        seq_d       = seq_q;
        seq_d.go    = (seq_q.state == ST_SUCCESS);
        seq_d.alarm = (seq_q.state == ST_ALARM);
        wrong       = 1'b0;
        clear       = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (init_key) begin
                    seq_d.state = ST_ARMED;
                    seq_d.idx   = '0;
                end
            end
            ST_ARMED: begin
                if (want_hit) begin
                    seq_d.state = ST_PRESS;
                end else if (!init_only) begin
                    wrong = 1'b1;
                end
            end
            ST_PRESS: begin
                if (init_only) begin
                    if (seq_q.idx == LAST_IDX) begin
                        seq_d.state = ST_DONE;
                    end else begin
                        seq_d.state = ST_ARMED;
                        seq_d.idx   = seq_q.idx + 1'b1;
                    end
                end else if (!want_hit) begin
                    wrong = 1'b1;
                end
            end
            ST_DONE: begin
                if (all_low) begin
                    seq_d.state = ST_SUCCESS;
                    clear       = 1'b1;
                end else if (!init_only) begin
                    wrong = 1'b1;
                end
            end
            ST_SUCCESS: seq_d.state = ST_IDLE;
            ST_REJECT: begin
                if (!init_key) begin
                    seq_d.state = ST_IDLE;
                end
            end
            ST_ALARM: seq_d.state = ST_ALARM;
            default:  seq_d.state = ST_IDLE;
        endcase
        if (wrong) begin
            seq_d.state = last_chance ? ST_ALARM : ST_REJECT;
        end
        bump = wrong;
    end

    always_ff @(posedge clk) begin
        if (restart) begin
            seq_q <= '{state: ST_IDLE, idx: '0, go: 1'b0, alarm: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign go    = seq_q.go;
    assign alarm = seq_q.alarm;

    a_r1_restart_clears: assert property (@(posedge clk)
        restart |=> (!go && !alarm && seq_q.state == ST_IDLE));

    a_r7_alarm_sticky: assert property (@(posedge clk) disable iff (restart)
        alarm |=> alarm);

    a_r7_alarm_state_holds: assert property (@(posedge clk) disable iff (restart)
        (seq_q.state == ST_ALARM) |=> (seq_q.state == ST_ALARM));

    a_r9_go_single: assert property (@(posedge clk) disable iff (restart)
        go |=> !go);

    a_r9_outputs_exclusive: assert property (@(posedge clk) disable iff (restart)
        !(go && alarm));

    a_r6_reject_holds: assert property (@(posedge clk) disable iff (restart)
        (seq_q.state == ST_REJECT && init_key) |=> (seq_q.state == ST_REJECT));

    a_r10_idle_needs_init: assert property (@(posedge clk) disable iff (restart)
        (seq_q.state == ST_IDLE && !init_key) |=> (seq_q.state == ST_IDLE));

endmodule

// File: rtl/keypad_lock.sv
module keypad_lock
    import keypad_lock_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter logic [NUM_DIGITS*KEY_SEL_W-1:0] CODE = 16'h1724,
    parameter int MAX_FAILS = 3
) (
    input  logic                 clk,
    input  logic                 restart,
    input  logic                 init_key,
    input  logic [KEY_COUNT-1:0] digit_keys,
    output logic                 go,
    output logic                 alarm
);

    localparam int FAIL_W = $clog2(MAX_FAILS + 1);

    logic [KEY_SEL_W-1:0] want;
    logic                 all_low;
    logic                 init_only;
    logic                 want_hit;
    logic                 bump;
    logic                 clear;
    logic                 last_chance;
    logic [FAIL_W-1:0]    fail_count;

    kl_pattern_decode u_decode (
        .init_key   (init_key),
        .digit_keys (digit_keys),
        .want       (want),
        .all_low    (all_low),
        .init_only  (init_only),
        .want_hit   (want_hit)
    );

    kl_fail_counter #(
        .MAX_FAILS (MAX_FAILS)
    ) u_fails (
        .clk         (clk),
        .restart     (restart),
        .bump        (bump),
        .clear       (clear),
        .count       (fail_count),
        .last_chance (last_chance)
    );

    kl_sequencer #(
        .NUM_DIGITS (NUM_DIGITS),
        .CODE       (CODE)
    ) u_seq (
        .clk         (clk),
        .restart     (restart),
        .init_key    (init_key),
        .all_low     (all_low),
        .init_only   (init_only),
        .want_hit    (want_hit),
        .last_chance (last_chance),
        .want        (want),
        .bump        (bump),
        .clear       (clear),
        .go          (go),
        .alarm       (alarm)
    );

    a_r8_go_after_clear: assert property (@(posedge clk) disable iff (restart)
        go |-> (fail_count == '0));

    a_r7_alarm_at_limit: assert property (@(posedge clk) disable iff (restart)
        alarm |-> (fail_count == FAIL_W'(MAX_FAILS)));

endmodule

// File: tb/tb_keypad_lock.sv
`timescale 1ns/1ps
module tb_keypad_lock;

    localparam int LIMIT = 3;
    localparam int CODE_SEQ [4] = '{1, 7, 2, 4};

    logic       clk = 1'b0;
    logic       restart;
    logic       init_key;
    logic [9:0] digit_keys;
    wire        go;
    wire        alarm;

    int  n_checks = 0;
    int  n_fails  = 0;
    int  exp_fails = 0;
    bit  done = 1'b0;

    keypad_lock dut (
        .clk        (clk),
        .restart    (restart),
        .init_key   (init_key),
        .digit_keys (digit_keys),
        .go         (go),
        .alarm      (alarm)
    );

    always #2.5 clk = ~clk;

    function automatic logic [9:0] onehot(int v);
        return 10'(1) << v;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic i, logic [9:0] d);
        @(negedge clk);
        init_key   = i;
        digit_keys = d;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_restart();
        @(negedge clk);
        restart    = 1'b1;
        init_key   = 1'b0;
        digit_keys = '0;
        @(negedge clk);
        chk("R1 go after restart", go, 1'b0);
        chk("R1 alarm after restart", alarm, 1'b0);
        restart = 1'b0;
        exp_fails = 0;
    endtask

    task automatic play_code(int h, bit finish);
        for (int r = 0; r < h; r++) step(1'b1, '0);
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < h; r++) step(1'b1, onehot(CODE_SEQ[k]));
            for (int r = 0; r < h; r++) step(1'b1, '0);
        end
        if (finish) step(1'b0, '0);
    endtask

    task automatic do_success(int h);
        play_code(h, 1'b1);
        tick();
        chk("R4 go not yet", go, 1'b0);
        tick();
        chk("R4 go pulse", go, 1'b1);
        chk("R9 alarm low with go", alarm, 1'b0);
        tick();
        chk("R9 go one cycle", go, 1'b0);
        exp_fails = 0;
    endtask

    task automatic inject(int k, int kind);
        int d;
        d = CODE_SEQ[k];
        case (kind)
            0:       step(1'b1, onehot((d + 1) % 10));
            1:       step(1'b1, onehot(d) | onehot((d + 5) % 10));
            default: step(1'b0, onehot(d));
        endcase
    endtask

    task automatic do_wrong(int pos, int kind);
        step(1'b1, '0);
        for (int k = 0; k < 4; k++) begin
            if (pos == 2 * k) begin
                inject(k, kind);
                return;
            end
            step(1'b1, onehot(CODE_SEQ[k]));
            step(1'b1, onehot(CODE_SEQ[k]));
            if (pos == 2 * k + 1) begin
                inject(k, kind);
                return;
            end
            step(1'b1, '0);
        end
        inject(3, kind);
    endtask

    task automatic wrong_checked(int pos, int kind);
        do_wrong(pos, kind);
        exp_fails++;
        tick();
        chk("R7 alarm latency", alarm, 1'b0);
        tick();
        chk("R5 alarm vs failure count", alarm, logic'(exp_fails >= LIMIT));
        chk("R5 no go on wrong", go, 1'b0);
    endtask

    initial begin
        restart    = 1'b1;
        init_key   = 1'b0;
        digit_keys = '0;
        repeat (3) tick();
        chk("R1 reset go", go, 1'b0);
        chk("R1 reset alarm", alarm, 1'b0);
        restart = 1'b0;

        // R10: stray digits while idle, then a normal entry
        for (int v = 0; v < 10; v++) step(1'b0, onehot(v));
        step(1'b0, 10'h3FF);
        step(1'b0, '0);
        tick();
        chk("R10 idle digits ignored go", go, 1'b0);
        chk("R10 idle digits ignored alarm", alarm, 1'b0);
        do_success(1);

        // R2 R3: several hold lengths
        for (int h = 1; h <= 4; h++) do_success(h);

        // R5 R6 R7 R8: wrong pattern at every position, three kinds
        for (int c = 0; c < 27; c++) begin
            wrong_checked(c % 9, c / 9);
            if (exp_fails >= LIMIT) begin
                play_code(2, 1'b1);
                repeat (3) begin
                    tick();
                    chk("R7 alarm sticky", alarm, 1'b1);
                    chk("R7 no go in alarm", go, 1'b0);
                end
                do_restart();
                do_success(1);
            end else begin
                if (c / 9 < 2) begin
                    play_code(1, 1'b1);
                    repeat (3) begin
                        tick();
                        chk("R6 entry ignored after wrong", go, 1'b0);
                    end
                end else begin
                    step(1'b0, '0);
                end
                if (c % 5 == 1) do_success(1);
            end
        end

        // R1: restart on the edge of the limit-reaching wrong pattern
        do_restart();
        wrong_checked(0, 0);
        step(1'b0, '0);
        wrong_checked(3, 0);
        step(1'b0, '0);
        step(1'b1, '0);
        @(negedge clk);
        restart    = 1'b1;
        digit_keys = onehot(9);
        @(negedge clk);
        restart    = 1'b0;
        init_key   = 1'b0;
        digit_keys = '0;
        exp_fails  = 0;
        tick();
        chk("R1 restart beats third wrong", alarm, 1'b0);
        tick();
        chk("R1 restart beats third wrong later", alarm, 1'b0);
        wrong_checked(5, 1);
        step(1'b0, '0);
        wrong_checked(8, 2);
        step(1'b0, '0);
        wrong_checked(2, 0);
        chk("R8 limit counted from restart", alarm, 1'b1);
        do_restart();

        // R1: restart on the completing edge suppresses go
        play_code(1, 1'b0);
        @(negedge clk);
        restart    = 1'b1;
        init_key   = 1'b0;
        digit_keys = '0;
        @(negedge clk);
        restart = 1'b0;
        repeat (3) begin
            chk("R1 restart beats completion", go, 1'b0);
            tick();
        end
        do_success(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule